// File: doc/BRIEF.md
# Inter-Processor Interrupt and Mailbox Register Block

This block holds the doorbell and hand-off registers for one node of processor cores. Each core owns a bank that contains a pending-interrupt word, an enable mask, two write-only strobe registers that raise or drop pending bits, and a small mailbox of 64-bit words. Any core can ring another core by writing ones into the target's raise register. The target sees its interrupt line go high when a pending bit is also enabled. It then reads its pending word and writes the same value to its drop register to acknowledge.

The mailbox carries start-up data to a sleeping secondary core. The boot core writes the upper words first and the entry address word last. A nonzero entry word tells the secondary that the hand-off is complete. The secondary writes that word back to zero once it has started. A per-core ready output follows the entry word. The block has two identical register ports, so two cores can reach it in the same cycle. Each port presents an address, write data, an access-size flag, write and read strobes, and receives read data in the same cycle.

Top module: `ipi_mailbox_node`

## Requirements
- R1: After reset, every pending word, enable mask and mailbox word is zero, every `irq_o` and `mbox_ready_o` bit is low, and reads return zero.
- R2: Address bits [11:8] select the core bank and bits [7:0] select the register. The offsets are 0x00 pending, 0x04 enable, 0x08 raise, 0x0C drop, and mailbox words 0 to 3 at 0x20, 0x28, 0x30 and 0x38. Banks are independent of each other.
- R3: A write to raise sets every pending bit whose data bit is 1 and leaves the other bits alone. Raise and drop read as zero.
- R4: A write to drop clears every pending bit whose data bit is 1 and leaves the other bits alone.
- R5: When one port raises a bit and the other port drops the same bit of the same core in one cycle, the bit ends up set.
- R6: `irq_o[c]` is the OR of core c's pending AND enable. It changes on the clock edge that takes the write, so a bit pending while disabled interrupts once it is enabled.
- R7: Mailbox words are written only by 64-bit accesses (`size64_i`=1), and 32-bit writes to them are ignored. A 64-bit read returns the whole word, and a 32-bit read returns the low 32 bits zero-extended.
- R8: `mbox_ready_o[c]` is high exactly while mailbox word 0 of core c is nonzero. The other mailbox words do not affect it.
- R9: An unmapped offset, or a core field of NUM_CORES or more, reads as zero and ignores writes.
- R10: When both ports write the enable mask of the same core in one cycle, port 0's data is kept. Writes that the two ports make to different cores in one cycle both take effect.
- R11: Read data is zero when the port's read strobe is low. Reads of the 32-bit registers are zero-extended to 64 bits at either access size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2*12 | Per-port byte address, port p at [p*12 +: 12] |
| wdata_i | input | 2*64 | Per-port write data |
| size64_i | input | 2 | Per-port access size: 1 = 64-bit, 0 = 32-bit |
| we_i | input | 2 | Per-port write strobe |
| re_i | input | 2 | Per-port read strobe |
| rdata_o | output | 2*64 | Per-port read data, combinational |
| irq_o | output | 4 | Per-core interrupt request |
| mbox_ready_o | output | 4 | Per-core mailbox-ready flag |

## Verification
The doorbell path is driven with raise masks that hold several bits, all-zero masks, drop masks that hit only some of the set bits, and enable masks that cover all, part or none of the pending bits. This shows whether raise and drop act per bit and whether the interrupt gates on enable rather than on pending alone. Same-cycle traffic on both ports separates raise-over-drop priority, port-0 priority on enable, and independence between banks. Mailbox accesses at both sizes, together with writes to word 0 and word 3, show the size rule and that ready depends on word 0 alone. Accesses to unmapped offsets and to a core index past the last bank catch address aliasing.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int BUS_W     = 64;
  localparam int BANK_LSB  = 8;
  localparam logic [7:0] OFF_STAT = 8'h00;
  localparam logic [7:0] OFF_EN   = 8'h04;
  localparam logic [7:0] OFF_SET  = 8'h08;
  localparam logic [7:0] OFF_CLR  = 8'h0C;
  localparam logic [7:0] OFF_MBOX = 8'h20;

  typedef enum logic [2:0] {
    K_NONE, K_STAT, K_EN, K_SET, K_CLR, K_MBOX
  } reg_kind_e;
endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
  import ipi_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_CORES  = 4,
  parameter int MBOX_WORDS = 4,
  localparam int CIDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int WORD_W    = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_kind_e         kind_o,
  output logic [CIDX_W-1:0] core_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int MBOX_END = int'(OFF_MBOX) + 8 * MBOX_WORDS;

  logic [7:0]               off;
  logic [ADDR_W-BANK_LSB-1:0] cfield;
  logic                     core_ok;
  logic [7:0]               moff;

  assign off     = addr_i[BANK_LSB-1:0];
  assign cfield  = addr_i[ADDR_W-1:BANK_LSB];
  assign core_ok = int'(cfield) < NUM_CORES;
  assign core_o  = cfield[CIDX_W-1:0];
  assign moff    = off - OFF_MBOX;
  assign word_o  = WORD_W'(moff >> 3);

  always_comb begin
    kind_o = K_NONE;
    if (core_ok) begin
      if (off == OFF_STAT)     kind_o = K_STAT;
      else if (off == OFF_EN)  kind_o = K_EN;
      else if (off == OFF_SET) kind_o = K_SET;
      else if (off == OFF_CLR) kind_o = K_CLR;
      else if (off >= OFF_MBOX && int'(off) < MBOX_END && off[2:0] == 3'd0)
        kind_o = K_MBOX;
    end
  end
endmodule

// File: rtl/ipi_core_bank.sv
module ipi_core_bank #(
  parameter int STAT_W     = 32,
  parameter int MBOX_WORDS = 4,
  parameter int MBOX_W     = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [STAT_W-1:0]            set_i,
  input  logic [STAT_W-1:0]            clr_i,
  input  logic                         en_we_i,
  input  logic [STAT_W-1:0]            en_data_i,
  input  logic [MBOX_WORDS-1:0]        mbox_we_i,
  input  logic [MBOX_WORDS*MBOX_W-1:0] mbox_data_i,
  output logic [STAT_W-1:0]            status_o,
  output logic [STAT_W-1:0]            enable_o,
  output logic [MBOX_WORDS*MBOX_W-1:0] mbox_o,
  output logic                         irq_o,
  output logic                         ready_o
);
  logic [STAT_W-1:0] status_q, enable_q;

  // set takes priority over clear on the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= (status_q & ~clr_i) | set_i;
      if (en_we_i) enable_q <= en_data_i;
    end
  end

  for (genvar w = 0; w < MBOX_WORDS; w++) begin : g_word
    logic [MBOX_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          word_q <= '0;
      else if (mbox_we_i[w]) word_q <= mbox_data_i[w*MBOX_W +: MBOX_W];
    end
    assign mbox_o[w*MBOX_W +: MBOX_W] = word_q;
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign irq_o    = |(status_q & enable_q);
  assign ready_o  = |mbox_o[MBOX_W-1:0];

  assert_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(status_q));
  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((status_q & $past(clr_i & ~set_i)) == '0));
  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i & clr_i) != '0) |=> ((status_q & $past(set_i & clr_i)) == $past(set_i & clr_i)));
  assert_irq_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_q == '0) |-> !irq_o);
  assert_mbox_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mbox_we_i == '0) |=> $stable(mbox_o));
endmodule

// File: rtl/ipi_mailbox_node.sv
module ipi_mailbox_node
  import ipi_pkg::*;
#(
  parameter int NUM_PORTS  = 2,
  parameter int NUM_CORES  = 4,
  parameter int ADDR_W     = 12,
  parameter int STAT_W     = 32,
  parameter int MBOX_WORDS = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PORTS*ADDR_W-1:0] addr_i,
  input  logic [NUM_PORTS*BUS_W-1:0]  wdata_i,
  input  logic [NUM_PORTS-1:0]        size64_i,
  input  logic [NUM_PORTS-1:0]        we_i,
  input  logic [NUM_PORTS-1:0]        re_i,
  output logic [NUM_PORTS*BUS_W-1:0]  rdata_o,
  output logic [NUM_CORES-1:0]        irq_o,
  output logic [NUM_CORES-1:0]        mbox_ready_o
);
  localparam int CIDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
  localparam int WORD_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1;
  localparam int MBOX_FLAT = MBOX_WORDS * BUS_W;

  reg_kind_e         dkind [NUM_PORTS];
  logic [CIDX_W-1:0] dcore [NUM_PORTS];
  logic [WORD_W-1:0] dword [NUM_PORTS];
  logic [BUS_W-1:0]  wd    [NUM_PORTS];

  logic [STAT_W-1:0]     set_m  [NUM_CORES];
  logic [STAT_W-1:0]     clr_m  [NUM_CORES];
  logic                  en_we  [NUM_CORES];
  logic [STAT_W-1:0]     en_d   [NUM_CORES];
  logic [MBOX_WORDS-1:0] mb_we  [NUM_CORES];
  logic [MBOX_FLAT-1:0]  mb_d   [NUM_CORES];
  logic [STAT_W-1:0]     stat_w [NUM_CORES];
  logic [STAT_W-1:0]     en_w   [NUM_CORES];
  logic [MBOX_FLAT-1:0]  mb_w   [NUM_CORES];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign wd[p] = wdata_i[p*BUS_W +: BUS_W];
    ipi_addr_decode #(
      .ADDR_W(ADDR_W), .NUM_CORES(NUM_CORES), .MBOX_WORDS(MBOX_WORDS)
    ) u_dec (
      .addr_i(addr_i[p*ADDR_W +: ADDR_W]),
      .kind_o(dkind[p]),
      .core_o(dcore[p]),
      .word_o(dword[p])
    );

    logic [BUS_W-1:0] rd;
    always_comb begin
      rd = '0;
      if (re_i[p]) begin
        case (dkind[p])
          K_STAT: rd = BUS_W'(stat_w[dcore[p]]);
          K_EN:   rd = BUS_W'(en_w[dcore[p]]);
          K_MBOX: begin
            rd = mb_w[dcore[p]][int'(dword[p])*BUS_W +: BUS_W];
            if (!size64_i[p]) rd[BUS_W-1:32] = '0;
          end
          default: rd = '0;
        endcase
      end
    end
    assign rdata_o[p*BUS_W +: BUS_W] = rd;
  end

  // lowest-numbered port is applied last so it wins on register writes
  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      set_m[c] = '0;
      clr_m[c] = '0;
      en_we[c] = 1'b0;
      en_d[c]  = '0;
      mb_we[c] = '0;
      mb_d[c]  = '0;
      for (int p = NUM_PORTS - 1; p >= 0; p--) begin
        if (we_i[p] && dcore[p] == CIDX_W'(c)) begin
          case (dkind[p])
            K_SET: set_m[c] = set_m[c] | wd[p][STAT_W-1:0];
            K_CLR: clr_m[c] = clr_m[c] | wd[p][STAT_W-1:0];
            K_EN: begin
              en_we[c] = 1'b1;
              en_d[c]  = wd[p][STAT_W-1:0];
            end
            K_MBOX: if (size64_i[p]) begin
              mb_we[c][dword[p]] = 1'b1;
              mb_d[c][int'(dword[p])*BUS_W +: BUS_W] = wd[p];
            end
            default: ;
          endcase
        end
      end
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    ipi_core_bank #(
      .STAT_W(STAT_W), .MBOX_WORDS(MBOX_WORDS), .MBOX_W(BUS_W)
    ) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .set_i       (set_m[c]),
      .clr_i       (clr_m[c]),
      .en_we_i     (en_we[c]),
      .en_data_i   (en_d[c]),
      .mbox_we_i   (mb_we[c]),
      .mbox_data_i (mb_d[c]),
      .status_o    (stat_w[c]),
      .enable_o    (en_w[c]),
      .mbox_o      (mb_w[c]),
      .irq_o       (irq_o[c]),
      .ready_o     (mbox_ready_o[c])
    );

    logic hit0, hit1;
    assign hit0 = we_i[0] && dkind[0] == K_EN && dcore[0] == CIDX_W'(c);
    assign hit1 = (NUM_PORTS > 1) && we_i[NUM_PORTS-1] && dkind[NUM_PORTS-1] == K_EN
                  && dcore[NUM_PORTS-1] == CIDX_W'(c);

    assert_port0_enable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit0 && hit1) |=> (en_w[c] == $past(wd[0][STAT_W-1:0])));
  end
endmodule

// File: tb/ipi_mailbox_node_tb_top.sv
`timescale 1ns/1ps
module ipi_mailbox_node_tb_top;
  localparam int NP = 2, NC = 4, AW = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP*AW-1:0] addr = '0;
  logic [NP*64-1:0] wdata = '0;
  logic [NP-1:0]    size64 = '0, we = '0, re = '0;
  logic [NP*64-1:0] rdata;
  logic [NC-1:0]    irq, ready;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ipi_mailbox_node dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .size64_i(size64), .we_i(we), .re_i(re), .rdata_o(rdata),
    .irq_o(irq), .mbox_ready_o(ready)
  );

  typedef enum logic [1:0] {OP_WR, OP_RD, OP_IRQ, OP_RDY} op_e;
  typedef struct packed {
    op_e         op;
    logic        port;
    logic [11:0] addr;
    logic        sz;
    logic [63:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VEC [NV] = '{
    '{OP_RD,  1'b0, 12'h000, 1'b0, 64'h0, 4'd1},                   // R1
    '{OP_IRQ, 1'b0, 12'h000, 1'b0, 64'h0, 4'd1},                   // R1
    '{OP_RDY, 1'b0, 12'h000, 1'b0, 64'h0, 4'd1},                   // R1
    '{OP_WR,  1'b0, 12'h108, 1'b0, 64'h5, 4'd3},                   // R3
    '{OP_RD,  1'b0, 12'h100, 1'b0, 64'h5, 4'd3},                   // R3
    '{OP_IRQ, 1'b0, 12'h000, 1'b0, 64'h0, 4'd6},                   // R6 disabled
    '{OP_WR,  1'b0, 12'h104, 1'b0, 64'h4, 4'd6},                   // R6
    '{OP_IRQ, 1'b0, 12'h000, 1'b0, 64'h2, 4'd6},                   // R6
    '{OP_RD,  1'b1, 12'h108, 1'b0, 64'h0, 4'd3},                   // R3 raise reads 0
    '{OP_RD,  1'b1, 12'h10C, 1'b0, 64'h0, 4'd3},                   // R3 drop reads 0
    '{OP_WR,  1'b1, 12'h10C, 1'b0, 64'h4, 4'd4},                   // R4
    '{OP_RD,  1'b0, 12'h100, 1'b0, 64'h1, 4'd4},                   // R4
    '{OP_IRQ, 1'b0, 12'h000, 1'b0, 64'h0, 4'd6},                   // R6
    '{OP_WR,  1'b0, 12'h108, 1'b0, 64'h0, 4'd3},                   // R3 zero mask
    '{OP_RD,  1'b0, 12'h100, 1'b0, 64'h1, 4'd3},                   // R3
    '{OP_WR,  1'b0, 12'h10C, 1'b0, 64'h0, 4'd4},                   // R4 zero mask
    '{OP_RD,  1'b0, 12'h100, 1'b0, 64'h1, 4'd4},                   // R4
    '{OP_WR,  1'b0, 12'h208, 1'b0, 64'h8000_0000, 4'd2},           // R2
    '{OP_RD,  1'b1, 12'h200, 1'b0, 64'h8000_0000, 4'd2},           // R2
    '{OP_RD,  1'b1, 12'h100, 1'b0, 64'h1, 4'd2},                   // R2
    '{OP_WR,  1'b0, 12'h004, 1'b0, 64'hFFFF_FFFF, 4'd2},           // R2
    '{OP_RD,  1'b1, 12'h004, 1'b0, 64'hFFFF_FFFF, 4'd2},           // R2
    '{OP_RD,  1'b1, 12'h104, 1'b0, 64'h4, 4'd2},                   // R2
    '{OP_WR,  1'b0, 12'h320, 1'b1, 64'h8000_0000_1234_5678, 4'd7}, // R7
    '{OP_RDY, 1'b0, 12'h000, 1'b0, 64'h8, 4'd8},                   // R8
    '{OP_RD,  1'b1, 12'h320, 1'b1, 64'h8000_0000_1234_5678, 4'd7}, // R7
    '{OP_RD,  1'b1, 12'h320, 1'b0, 64'h1234_5678, 4'd7},           // R7
    '{OP_WR,  1'b0, 12'h338, 1'b1, 64'hAAAA_5555_0000_0001, 4'd7}, // R7
    '{OP_RD,  1'b1, 12'h338, 1'b1, 64'hAAAA_5555_0000_0001, 4'd7}, // R7
    '{OP_WR,  1'b0, 12'h328, 1'b0, 64'hFF, 4'd7},                  // R7 32-bit ignored
    '{OP_RD,  1'b0, 12'h328, 1'b1, 64'h0, 4'd7},                   // R7
    '{OP_WR,  1'b0, 12'h320, 1'b1, 64'h0, 4'd8},                   // R8
    '{OP_RDY, 1'b0, 12'h000, 1'b0, 64'h0, 4'd8},                   // R8 word3 still set
    '{OP_WR,  1'b0, 12'h010, 1'b0, 64'hFF, 4'd9},                  // R9
    '{OP_RD,  1'b0, 12'h010, 1'b0, 64'h0, 4'd9},                   // R9
    '{OP_WR,  1'b0, 12'h408, 1'b0, 64'hFF, 4'd9},                  // R9 core 4
    '{OP_RD,  1'b0, 12'h400, 1'b0, 64'h0, 4'd9},                   // R9
    '{OP_RD,  1'b0, 12'h000, 1'b0, 64'h0, 4'd9},                   // R9 no alias
    '{OP_IRQ, 1'b0, 12'h000, 1'b0, 64'h0, 4'd6},                   // R6
    '{OP_RD,  1'b0, 12'h100, 1'b1, 64'h1, 4'd11}                   // R11
  };

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%016h expected 0x%016h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(int p, logic [11:0] a, logic [63:0] d, logic s);
    @(negedge clk);
    addr[p*AW +: AW] = a; wdata[p*64 +: 64] = d; size64[p] = s; we[p] = 1'b1;
    @(negedge clk);
    we[p] = 1'b0;
  endtask

  task automatic bus_rd(int p, logic [11:0] a, logic s, output logic [63:0] d);
    @(negedge clk);
    addr[p*AW +: AW] = a; size64[p] = s; re[p] = 1'b1;
    #1 d = rdata[p*64 +: 64];
    re[p] = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      case (VEC[i].op)
        OP_WR: bus_wr(int'(VEC[i].port), VEC[i].addr, VEC[i].data, VEC[i].sz);
        OP_RD: begin
          bus_rd(int'(VEC[i].port), VEC[i].addr, VEC[i].sz, v);
          check(tag, v, VEC[i].data);
        end
        OP_IRQ: begin @(negedge clk); #1 check(tag, 64'(irq), VEC[i].data); end
        default: begin @(negedge clk); #1 check(tag, 64'(ready), VEC[i].data); end
      endcase
    end

    // R11: read strobe low gives zero data
    @(negedge clk);
    addr[0 +: AW] = 12'h100; re[0] = 1'b0;
    #1 check("R11 re low", rdata[0 +: 64], 64'h0);

    // R5: raise on port 0 and drop on port 1, same core and cycle
    bus_wr(0, 12'h008, 64'h2, 1'b0);
    @(negedge clk);
    addr = {12'h00C, 12'h008}; wdata = {64'h3, 64'h1}; size64 = '0; we = 2'b11;
    @(negedge clk);
    we = '0;
    bus_rd(1, 12'h000, 1'b0, v);
    check("R5 raise wins", v, 64'h1);
    @(negedge clk); #1 check("R6 irq core0", 64'(irq), 64'h1);

    // R10: both ports write enable of core 3; port 0 kept
    @(negedge clk);
    addr = {12'h304, 12'h304}; wdata = {64'h0F, 64'hF0}; we = 2'b11;
    @(negedge clk);
    we = '0;
    bus_rd(0, 12'h304, 1'b0, v);
    check("R10 port0 enable", v, 64'hF0);

    // R10: different cores in one cycle both land
    @(negedge clk);
    addr = {12'h208, 12'h108}; wdata = {64'h100, 64'h100}; we = 2'b11;
    @(negedge clk);
    we = '0;
    bus_rd(0, 12'h100, 1'b0, v);
    check("R10 core1", v, 64'h101);
    bus_rd(1, 12'h200, 1'b0, v);
    check("R10 core2", v, 64'h8000_0100);

    // R1: reset again clears everything
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1 irq in reset", 64'(irq), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    bus_rd(0, 12'h100, 1'b0, v);
    check("R1 status after reset", v, 64'h0);
    bus_rd(0, 12'h004, 1'b0, v);
    check("R1 enable after reset", v, 64'h0);
    bus_rd(1, 12'h338, 1'b1, v);
    check("R1 mailbox after reset", v, 64'h0);
    #1 check("R1 ready after reset", 64'(ready), 64'h0);

    finish_run();
  end
endmodule